// File: doc/BRIEF.md
# PLL Feedback Divider Calculator

This block turns a reference clock frequency, given in hertz, into the feedback-divider settings for a USB PHY PLL. The PLL runs its VCO at a fixed 2880 MHz from a doubled reference. The block computes an integer divider and a 16-bit fraction that together set the loop ratio. It then assembles the 32-bit PLL control word that a register path would write.

A start strobe launches each calculation. A reference outside the allowed window is rejected at once. An accepted reference goes through a restoring shift-subtract divider that resolves one quotient bit per clock. When the calculation ends, done pulses for one cycle. On success the three result outputs are updated. On a reject the range flag is raised and the previous results are kept.

Top module: `pll_div_calc`

## Requirements
- R1: After reset, busy, done and range_err are 0, and int_div, frac_div and ctrl_word are all zero.
- R2: A reference from 19,200,000 to 38,400,000 Hz inclusive is accepted. Any other value completes with done and range_err both 1, and int_div, frac_div and ctrl_word keep their previous values.
- R3: On success, int_div equals floor(1,440,000,000 / ref_hz), which is the integer part of 2880e6 / (2 × ref_hz).
- R4: On success, frac_div equals floor(1,440,000,000 × 65536 / ref_hz) − int_div × 65536.
- R5: On success, ctrl_word carries int_div in bits [6:0]. Bits 31, 30 and 28 are 1. Bits 27, 26 and [9:7] are 0.
- R6: On success with a non-zero fraction, ctrl_word bit 29 is 1 and bits [25:10] hold frac_div. With a zero fraction, bit 29 and bits [25:10] are 0.
- R7: done is high for exactly one cycle per completion. For a reject, done is high in the cycle after the clock edge that samples start. For an accepted reference, done is high DIVIDEND_W+1 cycles after that edge (65 by default).
- R8: busy is high from the edge that samples start until the cycle in which done is high, inclusive. A start that arrives while busy is high is ignored: it produces no completion and does not change the result.
- R9: range_err stays at its value until the next completion, and an accepted reference clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a calculation; sampled when busy is low |
| ref_hz | input | 32 | Reference frequency in Hz, sampled with start |
| busy | output | 1 | A calculation is in progress or completing |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Last completion rejected the reference |
| int_div | output | 7 | Integer feedback divider |
| frac_div | output | 16 | Fractional feedback divider |
| ctrl_word | output | 32 | Packed PLL control word |

## Verification
The bench aims at both ends of the accepted window, the values one hertz outside it, and a zero reference. An off-by-one bound would flag a legal clock, or let an illegal one through to a divide. References that divide exactly (19.2, 24, 32 MHz) check that the fraction-control bit and the fraction field both stay clear; a packer that always set them would fail here. References with a remainder check the truncation of the fraction and its bit placement. Starts sent while a division is running, including one with an illegal value, must not produce a second done or change the latched quotient. The latency of every completion is measured against the cycle of its start, which catches a divider that runs one step short or long.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;
  localparam int unsigned REF_W  = 32;
  localparam int unsigned NDIV_W = 7;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned WORD_W = 32;

  // control-word bit positions decoded by the PLL register
  localparam int unsigned FRAC_LSB  = 10;
  localparam int unsigned EN_BIT    = 26;
  localparam int unsigned STRB_BIT  = 27;
  localparam int unsigned BYP_BIT   = 28;
  localparam int unsigned FCTL_BIT  = 29;
  localparam int unsigned DITH0_BIT = 30;
  localparam int unsigned DITH1_BIT = 31;

  localparam logic [REF_W-1:0] REF_LO = 32'd19_200_000;
  localparam logic [REF_W-1:0] REF_HI = 32'd38_400_000;

  function automatic logic ref_in_window(input logic [REF_W-1:0] f);
    return (f >= REF_LO) && (f <= REF_HI);
  endfunction

  function automatic logic [WORD_W-1:0] build_word(input logic [NDIV_W-1:0] nd,
                                                   input logic [FRAC_W-1:0] fr);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DITH1_BIT] = 1'b1;
    w[DITH0_BIT] = 1'b1;
    w[BYP_BIT]   = 1'b1;
    w[NDIV_W-1:0] = nd;
    if (fr != '0) begin
      w[FCTL_BIT] = 1'b1;
      w[FRAC_LSB +: FRAC_W] = fr;
    end
    return w;
  endfunction
endpackage

// File: rtl/ref_window_chk.sv
module ref_window_chk
  import pllcalc_pkg::*;
(
  input  logic [REF_W-1:0] ref_hz,
  output logic             in_range
);
  always_comb in_range = ref_in_window(ref_hz);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             valid,
  output logic [NUM_W-1:0] quot
);
  localparam int unsigned CNT_W = $clog2(NUM_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_W - 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [NUM_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, valid_q;

  logic [DEN_W:0] trial, diff;
  logic           fits, last_step;

  always_comb begin
    trial     = {rem_q, quo_q[NUM_W-1]};
    fits      = trial >= {1'b0, den_q};
    diff      = trial - {1'b0, den_q};
    last_step = (cnt_q == LAST_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (load && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= numer;
        den_q  <= denom;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (last_step) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign valid = valid_q;
  assign quot  = quo_q;

  // R2: only in-range (hence non-zero) divisors are ever loaded
  p_den_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (den_q != '0));
  // R4: partial remainder stays below the divisor after a subtract
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fits) |-> !diff[DEN_W]);
  // R7: a result only follows a running division
  p_valid_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(busy_q));
endmodule

// File: rtl/ctrl_word_pack.sv
module ctrl_word_pack
  import pllcalc_pkg::*;
(
  input  logic [NDIV_W-1:0] nd,
  input  logic [FRAC_W-1:0] fr,
  output logic [WORD_W-1:0] word
);
  always_comb word = build_word(nd, fr);
endmodule

// File: rtl/pll_div_calc.sv
module pll_div_calc
  import pllcalc_pkg::*;
#(
  parameter int unsigned DIVIDEND_W  = 64,
  parameter longint unsigned VCO_HALF_HZ = 64'd1_440_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REF_W-1:0]  ref_hz,
  output logic              busy,
  output logic              done,
  output logic              range_err,
  output logic [NDIV_W-1:0] int_div,
  output logic [FRAC_W-1:0] frac_div,
  output logic [WORD_W-1:0] ctrl_word
);
  localparam logic [DIVIDEND_W-1:0] NUMERATOR = DIVIDEND_W'(VCO_HALF_HZ) << FRAC_W;
  localparam int unsigned Q_USED = NDIV_W + FRAC_W;

  logic                  in_range, start_ok, div_load, reject;
  logic                  div_busy, div_valid;
  logic [DIVIDEND_W-1:0] quot;
  logic [NDIV_W-1:0]     q_nd;
  logic [FRAC_W-1:0]     q_fr;
  logic [WORD_W-1:0]     q_word;
  logic [DIVIDEND_W-Q_USED-1:0] q_hi;

  logic done_q, err_q;
  logic [NDIV_W-1:0] nd_q;
  logic [FRAC_W-1:0] fr_q;
  logic [WORD_W-1:0] word_q;

  ref_window_chk u_win (.ref_hz(ref_hz), .in_range(in_range));

  always_comb begin
    busy     = div_busy | div_valid | done_q;
    start_ok = start && !busy;
    div_load = start_ok && in_range;
    reject   = start_ok && !in_range;
    q_fr     = quot[FRAC_W-1:0];
    q_nd     = quot[FRAC_W +: NDIV_W];
    q_hi     = quot[DIVIDEND_W-1:Q_USED];
  end

  restoring_divider #(.NUM_W(DIVIDEND_W), .DEN_W(REF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load),
    .numer(NUMERATOR), .denom(ref_hz),
    .busy(div_busy), .valid(div_valid), .quot(quot)
  );

  ctrl_word_pack u_pack (.nd(q_nd), .fr(q_fr), .word(q_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      nd_q   <= '0;
      fr_q   <= '0;
      word_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (reject) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end else if (div_valid) begin
        done_q <= 1'b1;
        err_q  <= 1'b0;
        nd_q   <= q_nd;
        fr_q   <= q_fr;
        word_q <= q_word;
      end
    end
  end

  assign done      = done_q;
  assign range_err = err_q;
  assign int_div   = nd_q;
  assign frac_div  = fr_q;
  assign ctrl_word = word_q;

  // R3: quotient never exceeds the divider and fraction fields
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> (q_hi == '0));
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5: fixed control bits of a produced word
  p_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !err_q) |-> (word_q[DITH1_BIT] && word_q[DITH0_BIT] && word_q[BYP_BIT]
                            && !word_q[STRB_BIT] && !word_q[EN_BIT]));
  // R6: fraction-control bit tracks a non-zero fraction
  p_frac_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !err_q) |-> (word_q[FCTL_BIT] == (fr_q != '0)));
  // R2: results change only at a successful completion
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> (done_q && !err_q));
  // R9: range flag only rises with a completion
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> done_q);
endmodule

// File: tb/pll_div_calc_tb_top.sv
`timescale 1ns/1ps
module pll_div_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic        busy, done, range_err;
  logic [6:0]  int_div;
  logic [15:0] frac_div;
  logic [31:0] ctrl_word;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic        err;
    logic [6:0]  nd;
    logic [15:0] fr;
    logic [31:0] w;
    int          at;
  } exp_t;
  exp_t sb[$];

  logic [6:0]  last_nd = '0;
  logic [15:0] last_fr = '0;
  logic [31:0] last_w  = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_div_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
    .busy(busy), .done(done), .range_err(range_err),
    .int_div(int_div), .frac_div(frac_div), .ctrl_word(ctrl_word)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: computes the expectation from the requirements and queues it
  task automatic drive(input logic [31:0] f);
    exp_t e;
    longint unsigned q;
    bit ok;
    while (busy) @(negedge clk);
    ok = (f >= 32'd19200000) && (f <= 32'd38400000);
    if (ok) begin
      q = (64'd2880000000 * 64'd65536) / (64'd2 * f);
      last_nd = 7'(q / 65536);
      last_fr = 16'(q % 65536);
      last_w  = 32'hD000_0000 | {25'd0, last_nd};
      if (last_fr != 0) last_w = last_w | 32'h2000_0000 | ({16'd0, last_fr} << 10);
    end
    e.err = !ok;
    e.nd = last_nd; e.fr = last_fr; e.w = last_w;
    e.at = cyc + 1 + (ok ? 65 : 0);
    sb.push_back(e);
    start = 1'b1; ref_hz = f;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expectations as completions appear
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(0, "R7 done longer than one cycle", 1, 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R8 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(range_err == e.err, "R2/R9 range_err", range_err, e.err);
          chk(int_div == e.nd, "R3 int_div", int_div, e.nd);
          chk(frac_div == e.fr, "R4 frac_div", frac_div, e.fr);
          chk(ctrl_word == e.w, "R5/R6 ctrl_word", ctrl_word, e.w);
          chk(cyc == e.at, "R7 latency cycle", cyc, e.at);
          chk(busy == 1'b1, "R8 busy at done", busy, 1);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && range_err == 0, "R1 flags", {busy, done, range_err}, 0);
    chk(int_div == 0 && frac_div == 0 && ctrl_word == 0, "R1 results", ctrl_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 idle after reset", busy, 0);

    drive(32'd24000000);   // exact: frac zero (R6)
    drain();
    drive(32'd25000000);   // fractional (R4, R6)
    drain();
    drive(32'd19200000);   // lower bound accepted (R2)
    drain();
    drive(32'd38400000);   // upper bound accepted (R2)
    drain();
    drive(32'd19199999);   // just below: reject, outputs held (R2)
    drain();
    drive(32'd26000000);   // clears range_err (R9)
    drain();
    drive(32'd38400001);   // just above: reject
    drain();
    drive(32'd0);          // zero reference rejected
    drain();
    drive(32'd32000000);
    drain();
    drive(32'd30000000);
    drain();

    // R8: starts during a running division are ignored
    drive(32'd27000000);
    repeat (5) @(negedge clk);
    chk(busy == 1, "R8 busy during division", busy, 1);
    start = 1'b1; ref_hz = 32'd0;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; ref_hz = 32'd25000000;
    @(negedge clk); start = 1'b0;
    drain();
    repeat (80) @(negedge clk);
    chk(done == 0 && busy == 0, "R8 no extra completion", {done, busy}, 0);
    chk(ctrl_word == last_w, "R8 result unchanged", ctrl_word, last_w);

    drive(32'd33333333);
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule